// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block gathers level-sensitive request lines from on-chip peripherals and hands the processor two interrupt lines: a fast line and a normal line. Software sorts every request channel into one of three classes. A channel marked fast drives the fast line. A channel that is bound to an enabled priority slot is vectored. Any other channel is non-vectored. Vectored and non-vectored channels both drive the normal line. Per-channel enables mask each request before it is sorted. A software-request register is ORed into the raw lines, so firmware can raise any channel, including one channel that has no hardware source.

A handler reads the vector register to get the address of its service routine. That register holds the address stored in the highest-priority slot whose bound source is active. If no slot is active, it holds a shared default address. Slot 0 ranks above slot 15. Three status words are available. The raw word shows requests before masking. The fast word and the normal word show masked requests split by class.

Registers sit on a flat word-addressed bus. A write is taken on the clock edge while `wr_en_i` is high. Read data is a combinational function of `addr_i`. The word offsets are:

| Offset | Access | Register |
|---|---|---|
| 0x00 | read | fast status |
| 0x01 | read | normal status |
| 0x02 | read | raw status |
| 0x03 | read/write | class select |
| 0x04 | write-1-to-set, read | enable mask |
| 0x05 | write-1-to-clear, read | enable mask |
| 0x06 | write-1-to-set, read | software request |
| 0x07 | write-1-to-clear, read | software request |
| 0x08 | read; write = end of service | vector |
| 0x09 | read/write | default address |
| 0x40+k | read/write | handler address of slot k |
| 0x60+k | read/write | control word of slot k |

Top module: `vic_top`

## Requirements
- R1: Raw status (offset 0x02) equals `irq_src_i` OR the software-request word, except bit 1. Bit 1 comes only from the software-request word and ignores `irq_src_i[1]`.
- R2: A write to offset 0x04 sets each enable bit where the write data holds 1. A write to offset 0x05 clears each enable bit where the write data holds 1. Bits written with 0 are left as they were. Both offsets read back the enable mask.
- R3: Offsets 0x06 and 0x07 set and clear the software-request bits with the same write-1 rules as R2. Both offsets read back the software-request word.
- R4: A channel whose bit in the class-select word (offset 0x03) is 1 is fast. Fast status (offset 0x00) is raw AND enable AND class-select. `fiq_o` is high exactly when fast status is non-zero.
- R5: Normal status (offset 0x01) is raw AND enable AND NOT class-select. `irq_o` is high exactly when normal status is non-zero.
- R6: A slot control word holds the source channel in bits [4:0] and the slot enable in bit 5. Reading offset 0x08 returns the handler address of the lowest-numbered slot that meets both of these conditions: its enable bit is set, and its source channel is set in normal status.
- R7: When no slot matches, offset 0x08 returns the default address (offset 0x09).
- R8: A slot never matches if its enable bit is clear. A slot also never matches if its source number is 19 or higher.
- R9: A write to offset 0x08 ends a service. It changes no stored register. Both interrupt outputs stay the same, and the vector read stays the same.
- R10: After reset, every register reads 0, and both `fiq_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 19 | Level request lines from peripherals |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational) |
| fiq_o | output | 1 | Fast interrupt to the processor |
| irq_o | output | 1 | Normal interrupt to the processor |

## Verification
First, each channel is raised on its own, once with every channel in the normal class and once with alternate channels in the fast class. This shows that each channel is routed to the right status bit and output line, and that bit 1 depends only on the software-request word. Next, the slots are programmed in reverse channel order, with one slot disabled, one slot bound to a channel number that does not exist, and one slot bound to the software-only channel. Several hundred pseudo-random request, class and enable patterns are then applied. The test compares the vector read against a slot scan done in the bench, which separates the priority order from the channel order. Single-source cases aimed at the disabled slot and at the out-of-range slot must return the default address. A final end-of-service write with all bits set must leave every register read-back and both outputs unchanged.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned ADDR_W = 7;

  localparam logic [ADDR_W-1:0] OFF_STAT_FAST = 7'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT_NORM = 7'h01;
  localparam logic [ADDR_W-1:0] OFF_RAW       = 7'h02;
  localparam logic [ADDR_W-1:0] OFF_CLASS     = 7'h03;
  localparam logic [ADDR_W-1:0] OFF_EN_SET    = 7'h04;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR    = 7'h05;
  localparam logic [ADDR_W-1:0] OFF_SWI_SET   = 7'h06;
  localparam logic [ADDR_W-1:0] OFF_SWI_CLR   = 7'h07;
  localparam logic [ADDR_W-1:0] OFF_VEC       = 7'h08;
  localparam logic [ADDR_W-1:0] OFF_DEF       = 7'h09;

  // slot windows: [6:5]==2'b10 handler address, 2'b11 control
  localparam logic [1:0] WIN_SLOT_ADDR = 2'b10;
  localparam logic [1:0] WIN_SLOT_CTRL = 2'b11;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC  = 19,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned SRC_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [N_SRC-1:0]               en_o,
  output logic [N_SRC-1:0]               swi_o,
  output logic [N_SRC-1:0]               fast_o,
  output logic [N_SLOT-1:0][SRC_W-1:0]   slot_src_o,
  output logic [N_SLOT-1:0]              slot_en_o,
  output logic [N_SLOT-1:0][DATA_W-1:0]  slot_addr_o,
  output logic [DATA_W-1:0]              def_addr_o
);
  logic [N_SRC-1:0] en_q, swi_q, fast_q;
  logic [DATA_W-1:0] def_q;
  logic [N_SRC-1:0] wbits;

  assign wbits = wdata_i[N_SRC-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      swi_q  <= '0;
      fast_q <= '0;
      def_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        OFF_CLASS:   fast_q <= wbits;
        OFF_EN_SET:  en_q   <= en_q | wbits;
        OFF_EN_CLR:  en_q   <= en_q & ~wbits;
        OFF_SWI_SET: swi_q  <= swi_q | wbits;
        OFF_SWI_CLR: swi_q  <= swi_q & ~wbits;
        OFF_DEF:     def_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    logic [SRC_W-1:0]  src_q;
    logic              sen_q;
    logic [DATA_W-1:0] adr_q;
    logic hit_adr, hit_ctl;

    assign hit_adr = wr_en_i && (addr_i[6:5] == WIN_SLOT_ADDR) && (addr_i[4:0] == 5'(k));
    assign hit_ctl = wr_en_i && (addr_i[6:5] == WIN_SLOT_CTRL) && (addr_i[4:0] == 5'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q <= '0;
        sen_q <= 1'b0;
        adr_q <= '0;
      end else begin
        if (hit_adr) adr_q <= wdata_i;
        if (hit_ctl) begin
          src_q <= wdata_i[SRC_W-1:0];
          sen_q <= wdata_i[SRC_W];
        end
      end
    end

    assign slot_src_o[k]  = src_q;
    assign slot_en_o[k]   = sen_q;
    assign slot_addr_o[k] = adr_q;
  end

  assign en_o       = en_q;
  assign swi_o      = swi_q;
  assign fast_o     = fast_q;
  assign def_addr_o = def_q;

  p_en_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_EN_SET) |=> ((en_q & $past(wbits)) == $past(wbits)));
  p_en_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_EN_CLR) |=> ((en_q & $past(wbits)) == '0));
  p_swi_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_SWI_SET) |=> ((swi_q & $past(wbits)) == $past(wbits)));
  p_swi_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_SWI_CLR) |=> ((swi_q & $past(wbits)) == '0));
endmodule

// File: rtl/vic_classify.sv
module vic_classify #(
  parameter int unsigned N_SRC = 19,
  parameter int unsigned SW_CH = 1
) (
  input  logic [N_SRC-1:0] irq_src_i,
  input  logic [N_SRC-1:0] swi_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] fast_i,
  output logic [N_SRC-1:0] raw_o,
  output logic [N_SRC-1:0] fast_stat_o,
  output logic [N_SRC-1:0] norm_stat_o,
  output logic             fiq_o,
  output logic             irq_o
);
  // channel SW_CH has no hardware source
  localparam logic [N_SRC-1:0] HW_MASK = ~(N_SRC'(1) << SW_CH);

  logic [N_SRC-1:0] masked;

  assign raw_o       = (irq_src_i & HW_MASK) | swi_i;
  assign masked      = raw_o & en_i;
  assign fast_stat_o = masked & fast_i;
  assign norm_stat_o = masked & ~fast_i;
  assign fiq_o       = |fast_stat_o;
  assign irq_o       = |norm_stat_o;
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N_SRC  = 19,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned SRC_W  = 5,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  localparam int unsigned EXT_W = 1 << SRC_W
) (
  input  logic [N_SRC-1:0]               norm_stat_i,
  input  logic [N_SLOT-1:0][SRC_W-1:0]   slot_src_i,
  input  logic [N_SLOT-1:0]              slot_en_i,
  input  logic [N_SLOT-1:0][DATA_W-1:0]  slot_addr_i,
  input  logic [DATA_W-1:0]              def_addr_i,
  output logic [DATA_W-1:0]              vec_addr_o,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               hit_idx_o
);
  // out-of-range source numbers land on zero bits
  logic [EXT_W-1:0]  stat_ext;
  logic [N_SLOT-1:0] match;

  assign stat_ext = {{(EXT_W-N_SRC){1'b0}}, norm_stat_i};

  for (genvar k = 0; k < N_SLOT; k++) begin : g_match
    assign match[k] = slot_en_i[k] && stat_ext[slot_src_i[k]];
  end

  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int k = N_SLOT - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(k);
      end
    end
  end

  assign vec_addr_o = hit_o ? slot_addr_i[hit_idx_o] : def_addr_i;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC  = 19,
  parameter int unsigned N_SLOT = 16,
  parameter int unsigned SW_CH  = 1,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SRC_W = $clog2(N_SRC),
  localparam int unsigned IDX_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  localparam int unsigned EXT_W = 1 << SRC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fiq_o,
  output logic              irq_o
);
  logic [N_SRC-1:0]              en_q, swi_q, fast_q;
  logic [N_SLOT-1:0][SRC_W-1:0]  slot_src_q;
  logic [N_SLOT-1:0]             slot_en_q;
  logic [N_SLOT-1:0][DATA_W-1:0] slot_addr_q;
  logic [DATA_W-1:0]             def_addr_q;
  logic [N_SRC-1:0]              raw, fast_stat, norm_stat;
  logic [DATA_W-1:0]             vec_addr;
  logic                          vec_hit;
  logic [IDX_W-1:0]              hit_idx;

  vic_regs #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .en_o(en_q), .swi_o(swi_q), .fast_o(fast_q),
    .slot_src_o(slot_src_q), .slot_en_o(slot_en_q),
    .slot_addr_o(slot_addr_q), .def_addr_o(def_addr_q)
  );

  vic_classify #(.N_SRC(N_SRC), .SW_CH(SW_CH)) u_class (
    .irq_src_i, .swi_i(swi_q), .en_i(en_q), .fast_i(fast_q),
    .raw_o(raw), .fast_stat_o(fast_stat), .norm_stat_o(norm_stat),
    .fiq_o, .irq_o
  );

  vic_prio #(.N_SRC(N_SRC), .N_SLOT(N_SLOT), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_prio (
    .norm_stat_i(norm_stat), .slot_src_i(slot_src_q), .slot_en_i(slot_en_q),
    .slot_addr_i(slot_addr_q), .def_addr_i(def_addr_q),
    .vec_addr_o(vec_addr), .hit_o(vec_hit), .hit_idx_o(hit_idx)
  );

  function automatic logic [DATA_W-1:0] zx(input logic [N_SRC-1:0] v);
    return {{(DATA_W-N_SRC){1'b0}}, v};
  endfunction

  logic [4:0] win_idx;
  assign win_idx = addr_i[4:0];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_STAT_FAST:          rdata_o = zx(fast_stat);
      OFF_STAT_NORM:          rdata_o = zx(norm_stat);
      OFF_RAW:                rdata_o = zx(raw);
      OFF_CLASS:              rdata_o = zx(fast_q);
      OFF_EN_SET, OFF_EN_CLR: rdata_o = zx(en_q);
      OFF_SWI_SET, OFF_SWI_CLR: rdata_o = zx(swi_q);
      OFF_VEC:                rdata_o = vec_addr;
      OFF_DEF:                rdata_o = def_addr_q;
      default: begin
        if (32'(win_idx) < N_SLOT) begin
          if (addr_i[6:5] == WIN_SLOT_ADDR)
            rdata_o = slot_addr_q[win_idx[IDX_W-1:0]];
          else if (addr_i[6:5] == WIN_SLOT_CTRL)
            rdata_o = DATA_W'({slot_en_q[win_idx[IDX_W-1:0]], slot_src_q[win_idx[IDX_W-1:0]]});
        end
      end
    endcase
  end

  logic [N_SRC-1:0] req_any;
  logic [EXT_W-1:0] norm_ext;
  assign req_any  = irq_src_i | swi_q;
  assign norm_ext = {{(EXT_W-N_SRC){1'b0}}, norm_stat};

  p_fiq_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> |(req_any & en_q & fast_q));
  p_irq_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(req_any & en_q & ~fast_q));
  p_hit_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_hit |-> (irq_o && norm_ext[slot_src_q[hit_idx]]));
  p_default_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_addr == def_addr_q));
  p_hit_enabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_hit |-> (slot_en_q[hit_idx] && 32'(slot_src_q[hit_idx]) < N_SRC));
  p_eos_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_VEC) |=>
      ($stable(en_q) && $stable(swi_q) && $stable(fast_q) && $stable(def_addr_q)
       && $stable(slot_en_q) && $stable(slot_src_q)));
endmodule

// File: tb/vic_top_tb.sv
`timescale 1ns/1ps
module vic_top_tb;
  localparam int NS = 19;
  localparam int NK = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] src = '0;
  logic        we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq, irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vic_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  // bench-side configuration mirror
  logic [18:0] m_en = '0, m_swi = '0, m_fast = '0;
  logic [31:0] m_def = '0;
  int          m_src [NK];
  bit          m_sen [NK];
  logic [31:0] m_adr [NK];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [18:0] e_raw();
    return (src & ~19'h2) | m_swi;
  endfunction
  function automatic logic [18:0] e_norm();
    return e_raw() & m_en & ~m_fast;
  endfunction
  function automatic logic [18:0] e_fast();
    return e_raw() & m_en & m_fast;
  endfunction
  function automatic logic [31:0] e_vec();
    logic [18:0] ns = e_norm();
    for (int k = 0; k < NK; k++)
      if (m_sen[k] && m_src[k] < NS && ns[m_src[k]]) return m_adr[k];
    return m_def;
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] r;
    rd(7'h02, r); chk({tag, " R1 raw"}, r, {13'd0, e_raw()});
    rd(7'h00, r); chk({tag, " R4 fast stat"}, r, {13'd0, e_fast()});
    chk({tag, " R4 fiq"}, {31'd0, fiq}, {31'd0, |e_fast()});
    rd(7'h01, r); chk({tag, " R5 norm stat"}, r, {13'd0, e_norm()});
    chk({tag, " R5 irq"}, {31'd0, irq}, {31'd0, |e_norm()});
    rd(7'h08, r); chk({tag, " R6/R7 vector"}, r, e_vec());
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] x;
    for (int k = 0; k < NK; k++) begin m_src[k] = 0; m_sen[k] = 0; m_adr[k] = '0; end
    #12 rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 fiq", {31'd0, fiq}, 32'd0);
    chk("R10 irq", {31'd0, irq}, 32'd0);
    foreach (x[i]) ;
    for (int a = 0; a < 10; a++) begin rd(7'(a), r); chk("R10 reg", r, 32'd0); end
    for (int k = 0; k < NK; k++) begin
      rd(7'h40 + 7'(k), r); chk("R10 slot addr", r, 32'd0);
      rd(7'h60 + 7'(k), r); chk("R10 slot ctrl", r, 32'd0);
    end

    // R2 enable write-1 set / clear
    wr(7'h04, 32'h0005_A5A5); m_en = 19'h5A5A5;
    wr(7'h04, 32'h0000_0F00); m_en |= 19'h00F00;
    rd(7'h04, r); chk("R2 en set", r, {13'd0, m_en});
    wr(7'h05, 32'h0000_8421); m_en &= ~19'h08421;
    rd(7'h05, r); chk("R2 en clr", r, {13'd0, m_en});
    // R3 software request
    wr(7'h06, 32'h0004_0003); m_swi = 19'h40003;
    rd(7'h06, r); chk("R3 swi set", r, {13'd0, m_swi});
    wr(7'h07, 32'h0004_0001); m_swi &= ~19'h40001;
    rd(7'h07, r); chk("R3 swi clr", r, {13'd0, m_swi});
    check_all("swi");
    wr(7'h07, 32'h0007_FFFF); m_swi = '0;

    // R1/R5 one-hot sweep, all normal; then R4 with alternate fast
    wr(7'h04, 32'h0007_FFFF); m_en = '1;
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < NS; c++) begin
        @(negedge clk); src = 19'(1) << c;
        check_all(pass == 0 ? "onehot" : "onehot fast");
      end
      wr(7'h03, 32'h0005_5555); m_fast = 19'h55555;
    end
    @(negedge clk); src = '0;
    wr(7'h06, 32'h2); m_swi = 19'h2;
    check_all("R1 ch1 swi");
    wr(7'h07, 32'h2); m_swi = '0;

    // slot programming: reverse channel order, slot 5 off, slot 6 bad source, slot 15 -> ch1
    wr(7'h09, 32'hDEAD_0000); m_def = 32'hDEAD_0000;
    for (int k = 0; k < NK; k++) begin
      m_src[k] = 18 - k; m_sen[k] = (k != 5); m_adr[k] = 32'h1000_0000 + 32'(k) * 16;
      if (k == 6) m_src[k] = 25;
      if (k == 15) m_src[k] = 1;
      wr(7'h40 + 7'(k), m_adr[k]);
      wr(7'h60 + 7'(k), {26'd0, m_sen[k], 5'(m_src[k])});
      rd(7'h60 + 7'(k), r); chk("R6 ctrl readback", r, {26'd0, m_sen[k], 5'(m_src[k])});
    end
    wr(7'h03, 32'h0); m_fast = '0;
    check_all("R7 idle");

    // R8 directed: only disabled slot's source, only bad-source slot's channel
    @(negedge clk); src = 19'(1) << 13; check_all("R8 slot off");
    @(negedge clk); src = 19'(1) << 12; check_all("R8 bad src");
    @(negedge clk); src = 19'(1) << 12 | 19'(1) << 3; check_all("R6 slot15 vs ch3");

    // pseudo-random pattern sweep
    x = 32'h1234_5678;
    for (int it = 0; it < 600; it++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      if (it % 8 == 0) begin
        wr(7'h03, {13'd0, x[31:13] & x[18:0]}); m_fast = x[31:13] & x[18:0];
        wr(7'h05, 32'h7FFFF); wr(7'h04, {13'd0, x[18:0] | x[31:13]});
        m_en = x[18:0] | x[31:13];
        wr(7'h07, 32'h7FFFF); wr(7'h06, {13'd0, x[15:14], 1'b0}); m_swi = {16'd0, x[15:14], 1'b0};
      end
      @(negedge clk); src = (it % 3 == 0) ? (19'(1) << (x[9:5] % 19)) : x[24:6];
      check_all("sweep");
    end

    // R9 end-of-service write changes nothing
    @(negedge clk); src = 19'h0_8100;
    begin
      logic [31:0] v0, s0, f0;
      logic i0, q0;
      rd(7'h08, v0); rd(7'h04, s0); rd(7'h03, f0); i0 = irq; q0 = fiq;
      wr(7'h08, 32'hFFFF_FFFF);
      rd(7'h08, r); chk("R9 vector", r, v0);
      rd(7'h04, r); chk("R9 enable", r, s0);
      rd(7'h03, r); chk("R9 class", r, f0);
      rd(7'h09, r); chk("R9 default", r, m_def);
      rd(7'h06, r); chk("R9 swi", r, {13'd0, m_swi});
      chk("R9 irq", {31'd0, irq}, {31'd0, i0});
      chk("R9 fiq", {31'd0, fiq}, {31'd0, q0});
      for (int k = 0; k < NK; k++) begin
        rd(7'h60 + 7'(k), r); chk("R9 slot ctrl", r, {26'd0, m_sen[k], 5'(m_src[k])});
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule